// File: doc/BRIEF.md
# Refresh-Slot Shared Wavetable Oscillator

This block runs two wavetable oscillators from one waveform RAM that a CPU also writes. Each oscillator turns a programmable period into a sample-clock enable: over every window of `period` system clocks it fires exactly 32 evenly spread sample ticks. The period is therefore the length of one base-rate cycle, and the sample rate is 32 times that base rate. On each of its own ticks an oscillator moves its 8-bit phase counter to the next table entry.

Table reads never compete with the CPU. A read happens only in a cycle that the CPU bus marks as a memory refresh slot. The low refresh-address bit in that slot picks which oscillator is served. The byte read is scaled by that oscillator's volume and held in a staging register. A separate output register copies the staging register on the oscillator's own sample tick. The output therefore steps at the oscillator's variable sample rate and not at the rate of the shared fetch slots.

Top module: `wt_refresh_osc`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, both waves, both ticks, all phases and all staging values are zero. The internal period registers load the maximum value.
- R2: For a period P of 32 or more, each oscillator gives exactly 32 ticks in any P consecutive clocks once it is in steady state. A period below 32 behaves as 32, which gives a tick on every clock. A new period takes effect one clock after it is applied.
- R3: Each tick advances that oscillator's phase by one, modulo 256. The table address for oscillator k is {k, phase}: bit 8 is the oscillator number and bits 7:0 are the phase.
- R4: With `refresh_slot` low, no table read occurs and the staging values do not change.
- R5: In a refresh slot, `refresh_bank`=0 serves oscillator 0 and `refresh_bank`=1 serves oscillator 1. The other oscillator's staging value is untouched.
- R6: A slot in cycle t reads table entry {k, phase_k(t)}. At the end of cycle t+1 the staging value becomes the upper 8 bits of sample × volume_k, using volume_k as it stands in cycle t+1.
- R7: A wave output changes only at the clock edge that ends a cycle in which its own tick is high. At that edge it loads the staging value held before the edge.
- R8: A CPU write (`cpu_we`) is performed when `refresh_slot` is low. It is ignored when `refresh_slot` is high.
- R9: If no slot serves an oscillator between two of its ticks, the second tick reloads the last staged value, even if the table has since been rewritten.
- R10: When a staging write and a tick of the same oscillator fall at one edge, the output takes the old staging value. The new value appears at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU table write strobe |
| cpu_waddr | input | 9 | Write address: bit 8 oscillator, bits 7:0 entry |
| cpu_wdata | input | 8 | Write data (unsigned sample) |
| refresh_slot | input | 1 | High in a CPU refresh cycle |
| refresh_bank | input | 1 | Low bit of the refresh address; selects the oscillator |
| period0 | input | 16 | Oscillator 0 base period in clocks |
| period1 | input | 16 | Oscillator 1 base period in clocks |
| volume0 | input | 8 | Oscillator 0 unsigned volume |
| volume1 | input | 8 | Oscillator 1 unsigned volume |
| tick0 | output | 1 | Oscillator 0 sample-clock enable |
| tick1 | output | 1 | Oscillator 1 sample-clock enable |
| wave0 | output | 8 | Oscillator 0 output sample |
| wave1 | output | 8 | Oscillator 1 output sample |

## Verification
Two events can land on the same edge: an oscillator's staging register being refilled by a completed slot fetch, and that oscillator's output register taking a sample tick. Short periods with a slot in every cycle make this happen constantly. Sparse slots every fiftieth cycle force repeated ticks with no new fetch. A cycle-level model built from R2, R3, R5, R6 and R7 predicts every output each clock, and the output must show the pre-edge staging value whenever the two events coincide.

// File: rtl/wt_osc_pkg.sv
package wt_osc_pkg;
  localparam int unsigned OSC_COUNT   = 2;
  localparam int unsigned PHASE_BITS  = 8;
  localparam int unsigned SAMPLE_BITS = 8;
  localparam int unsigned VOLUME_BITS = 8;
  localparam int unsigned PERIOD_BITS = 16;
  localparam int unsigned OVERSAMPLE  = 32;
endpackage

// File: rtl/wt_rate_gen.sv
module wt_rate_gen #(
  parameter int PER_W = 16,
  parameter int MULT  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  localparam int ACC_W = PER_W + 1;
  localparam logic [PER_W-1:0] MIN_PER = PER_W'(MULT);

  logic [PER_W-1:0] period_q;
  logic [PER_W-1:0] p_eff;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic             wrap;

  // periods shorter than the oversample factor are clamped so at most
  // one tick falls in any clock
  assign p_eff = (period_q < MIN_PER) ? MIN_PER : period_q;
  assign sum   = acc_q + ACC_W'(MULT);
  assign wrap  = (sum >= {1'b0, p_eff});

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '1;
      acc_q    <= '0;
      tick     <= 1'b0;
    end else begin
      period_q <= period;
      tick     <= wrap;
      if (wrap) begin
        acc_q <= sum - {1'b0, p_eff};
      end else begin
        acc_q <= sum;
      end
    end
  end

  // R2
  tick_every_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (p_eff == MIN_PER) |=> tick);

endmodule

// File: rtl/wt_table_ram.sv
module wt_table_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/wt_voice.sv
module wt_voice #(
  parameter int PHASE_W  = 8,
  parameter int SAMPLE_W = 8,
  parameter int VOL_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                fetch_valid,
  input  logic [SAMPLE_W-1:0] fetch_data,
  input  logic [VOL_W-1:0]    volume,
  output logic [PHASE_W-1:0]  phase,
  output logic [SAMPLE_W-1:0] stage,
  output logic [SAMPLE_W-1:0] wave
);
  localparam int PROD_W = SAMPLE_W + VOL_W;

  logic [PROD_W-1:0] product;
  assign product = fetch_data * volume;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      stage <= '0;
      wave  <= '0;
    end else begin
      if (fetch_valid) begin
        stage <= product[PROD_W-1 -: SAMPLE_W];
      end
      if (tick) begin
        wave  <= stage;
        phase <= phase + 1'b1;
      end
    end
  end

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (phase == $past(phase) + 1'b1));

  // R6
  scale_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (stage <= $past(fetch_data)));

  // R7
  wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(wave));

endmodule

// File: rtl/wt_refresh_osc.sv
module wt_refresh_osc
  import wt_osc_pkg::*;
#(
  parameter int PHASE_W  = PHASE_BITS,
  parameter int SAMPLE_W = SAMPLE_BITS,
  parameter int VOL_W    = VOLUME_BITS,
  parameter int PER_W    = PERIOD_BITS,
  parameter int MULT     = OVERSAMPLE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_we,
  input  logic [PHASE_W:0]    cpu_waddr,
  input  logic [SAMPLE_W-1:0] cpu_wdata,
  input  logic                refresh_slot,
  input  logic                refresh_bank,
  input  logic [PER_W-1:0]    period0,
  input  logic [PER_W-1:0]    period1,
  input  logic [VOL_W-1:0]    volume0,
  input  logic [VOL_W-1:0]    volume1,
  output logic                tick0,
  output logic                tick1,
  output logic [SAMPLE_W-1:0] wave0,
  output logic [SAMPLE_W-1:0] wave1
);
  localparam int NUM_OSC = OSC_COUNT;
  localparam int ADDR_W  = PHASE_W + 1;

  logic [PER_W-1:0]    period_a [NUM_OSC];
  logic [VOL_W-1:0]    volume_a [NUM_OSC];
  logic                tick_a   [NUM_OSC];
  logic [PHASE_W-1:0]  phase_a  [NUM_OSC];
  logic [SAMPLE_W-1:0] stage_a  [NUM_OSC];
  logic [SAMPLE_W-1:0] wave_a   [NUM_OSC];
  logic                fetch_v  [NUM_OSC];

  assign period_a[0] = period0;
  assign period_a[1] = period1;
  assign volume_a[0] = volume0;
  assign volume_a[1] = volume1;
  assign tick0 = tick_a[0];
  assign tick1 = tick_a[1];
  assign wave0 = wave_a[0];
  assign wave1 = wave_a[1];

  // shared table: CPU writes outside refresh slots, voices read inside them
  logic                ram_we;
  logic [ADDR_W-1:0]   ram_raddr;
  logic [SAMPLE_W-1:0] ram_rdata;
  logic                rd_valid_q;
  logic                rd_bank_q;

  assign ram_we    = cpu_we & ~refresh_slot;
  assign ram_raddr = {refresh_bank, phase_a[refresh_bank]};

  wt_table_ram #(
    .ADDR_W (ADDR_W),
    .DATA_W (SAMPLE_W)
  ) u_table (
    .clk   (clk),
    .we    (ram_we),
    .waddr (cpu_waddr),
    .wdata (cpu_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_bank_q  <= 1'b0;
    end else begin
      rd_valid_q <= refresh_slot;
      rd_bank_q  <= refresh_bank;
    end
  end

  for (genvar k = 0; k < NUM_OSC; k++) begin : g_osc
    assign fetch_v[k] = rd_valid_q && (rd_bank_q == 1'(k));

    wt_rate_gen #(
      .PER_W (PER_W),
      .MULT  (MULT)
    ) u_rate (
      .clk    (clk),
      .rst    (rst),
      .period (period_a[k]),
      .tick   (tick_a[k])
    );

    wt_voice #(
      .PHASE_W  (PHASE_W),
      .SAMPLE_W (SAMPLE_W),
      .VOL_W    (VOL_W)
    ) u_voice (
      .clk         (clk),
      .rst         (rst),
      .tick        (tick_a[k]),
      .fetch_valid (fetch_v[k]),
      .fetch_data  (ram_rdata),
      .volume      (volume_a[k]),
      .phase       (phase_a[k]),
      .stage       (stage_a[k]),
      .wave        (wave_a[k])
    );

    // R4
    no_slot_stage_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(refresh_slot, 2) |-> $stable(stage_a[k]));

    // R5
    other_bank_stage_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(refresh_slot, 2) && ($past(refresh_bank, 2) != 1'(k)))
        |-> $stable(stage_a[k]));
  end

endmodule

// File: tb/wt_refresh_osc_tb.sv
module wt_refresh_osc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 1'b0;
  logic [8:0]  cpu_waddr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        refresh_slot = 1'b0;
  logic        refresh_bank = 1'b0;
  logic [15:0] period0 = 16'd40;
  logic [15:0] period1 = 16'd40;
  logic [7:0]  volume0 = '0;
  logic [7:0]  volume1 = '0;
  logic        tick0, tick1;
  logic [7:0]  wave0, wave1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wt_refresh_osc u_dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr),
    .cpu_wdata(cpu_wdata), .refresh_slot(refresh_slot),
    .refresh_bank(refresh_bank), .period0(period0), .period1(period1),
    .volume0(volume0), .volume1(volume1), .tick0(tick0), .tick1(tick1),
    .wave0(wave0), .wave1(wave1)
  );

  // cycle model built from R2, R3, R5, R6, R7, R8
  logic [7:0]  m_mem [512];
  logic [15:0] m_per [2];
  logic [16:0] m_acc [2];
  logic        m_tick [2];
  logic [7:0]  m_ph [2];
  logic [7:0]  m_stage [2];
  logic [7:0]  m_wave [2];
  logic        m_rv, m_rb;
  logic [7:0]  m_rd;

  always @(posedge clk) begin
    if (cpu_we && !refresh_slot) m_mem[cpu_waddr] <= cpu_wdata;
    m_rd <= m_mem[{refresh_bank, m_ph[refresh_bank]}];
    if (rst) begin
      m_rv <= 1'b0;
      m_rb <= 1'b0;
      for (int k = 0; k < 2; k++) begin
        m_per[k] <= 16'hFFFF; m_acc[k] <= '0; m_tick[k] <= 1'b0;
        m_ph[k] <= '0; m_stage[k] <= '0; m_wave[k] <= '0;
      end
    end else begin
      m_rv <= refresh_slot;
      m_rb <= refresh_bank;
      for (int k = 0; k < 2; k++) begin
        int eff;
        int sum;
        logic [15:0] prod;
        eff = (m_per[k] < 16'd32) ? 32 : int'(m_per[k]);
        sum = int'(m_acc[k]) + 32;
        m_per[k] <= (k == 0) ? period0 : period1;
        if (sum >= eff) begin
          m_acc[k] <= 17'(sum - eff); m_tick[k] <= 1'b1;
        end else begin
          m_acc[k] <= 17'(sum); m_tick[k] <= 1'b0;
        end
        prod = 16'(m_rd) * 16'((k == 0) ? volume0 : volume1);
        if (m_rv && (m_rb == 1'(k))) m_stage[k] <= prod[15:8];
        if (m_tick[k]) begin
          m_wave[k] <= m_stage[k];
          m_ph[k] <= m_ph[k] + 8'd1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data, input bit slot, input bit bank);
    @(negedge clk);
    cpu_we = 1'b1; cpu_waddr = 9'(addr); cpu_wdata = 8'(data);
    refresh_slot = slot; refresh_bank = bank;
  endtask

  task automatic wr_done();
    @(negedge clk);
    cpu_we = 1'b0; refresh_slot = 1'b0;
  endtask

  // mode 0 alternate banks, 1 bank0 only, 2 bank1 only, 3 no slots
  task automatic run_slots(input int n, input int mode);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      refresh_slot = (mode != 3);
      refresh_bank = (mode == 0) ? c[0] : (mode == 2);
    end
    @(negedge clk);
    refresh_slot = 1'b0;
  endtask

  typedef struct packed {
    logic [15:0] p0;
    logic [15:0] p1;
    logic [7:0]  v0;
    logic [7:0]  v1;
    logic [1:0]  mode;
  } vec_t;

  // mode 0 slot each clock alternating, 1 every third, 2 every fiftieth,
  // 3 every clock bank 1 only
  localparam vec_t VECS [4] = '{
    '{16'd40, 16'd57,  8'd255, 8'd128, 2'd0},
    '{16'd33, 16'd100, 8'd90,  8'd255, 2'd1},
    '{16'd64, 16'd45,  8'd200, 8'd17,  2'd2},
    '{16'd50, 16'd31,  8'd255, 8'd255, 2'd3}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(wave0 == 8'd0, "R1 wave0 in reset", wave0, 0);
    chk(wave1 == 8'd0, "R1 wave1 in reset", wave1, 0);
    chk(!tick0 && !tick1, "R1 ticks in reset", {tick0, tick1}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tick0 && wave0 == 8'd0, "R1 first clock after reset", tick0, 0);

    // fill both tables with an address pattern, no slots yet
    for (int i = 0; i < 512; i++) wr(i, (i * 37 + 11) & 255, 1'b0, 1'b0);
    wr_done();

    // R4: ticks run but no slot ever served, so waves stay zero
    volume0 = 8'd255; volume1 = 8'd255;
    cnt = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      cnt += tick0;
    end
    chk(wave0 == 8'd0 && wave1 == 8'd0, "R4 no slot keeps waves", wave0 + wave1, 0);
    chk(cnt > 0, "R4 ticks were present", cnt, 1);

    // R2 tick density
    period0 = 16'd100; period1 = 16'd20;
    repeat (300) @(negedge clk);
    cnt = 0;
    for (int c = 0; c < 100; c++) begin
      cnt += tick0;
      @(negedge clk);
    end
    chk(cnt == 32, "R2 32 ticks per period", cnt, 32);
    cnt = 0;
    for (int c = 0; c < 100; c++) begin
      cnt += tick1;
      @(negedge clk);
    end
    chk(cnt == 100, "R2 short period clamps to 32", cnt, 100);

    // vector table walk against the cycle model
    foreach (VECS[r]) begin
      int mism;
      int holdbad;
      logic [7:0] pw0, pw1;
      logic pt0, pt1;
      mism = 0; holdbad = 0;
      period0 = VECS[r].p0; period1 = VECS[r].p1;
      volume0 = VECS[r].v0; volume1 = VECS[r].v1;
      pw0 = wave0; pw1 = wave1; pt0 = tick0; pt1 = tick1;
      for (int c = 0; c < 2000; c++) begin
        @(negedge clk);
        if (wave0 != m_wave[0] || wave1 != m_wave[1] ||
            tick0 != m_tick[0] || tick1 != m_tick[1]) mism++;
        if ((!pt0 && wave0 != pw0) || (!pt1 && wave1 != pw1)) holdbad++;
        pw0 = wave0; pw1 = wave1; pt0 = tick0; pt1 = tick1;
        case (VECS[r].mode)
          2'd0: begin refresh_slot = 1'b1; refresh_bank = c[0]; end
          2'd1: begin refresh_slot = (c % 3 == 0); refresh_bank = c[1]; end
          2'd2: begin refresh_slot = (c % 50 == 0); refresh_bank = ((c / 50) % 2 == 1); end
          default: begin refresh_slot = 1'b1; refresh_bank = 1'b1; end
        endcase
      end
      // R3 R5 R6 R9 R10: outputs match the model every clock
      chk(mism == 0, "R3/R5/R6/R9/R10 model row", mism, 0);
      chk(holdbad == 0, "R7 wave holds without tick", holdbad, 0);
    end
    @(negedge clk);
    refresh_slot = 1'b0;

    // R6 scaling with a flat table on oscillator 0
    period0 = 16'd40;
    for (int i = 0; i < 256; i++) wr(i, 200, 1'b0, 1'b0);
    wr_done();
    volume0 = 8'd128;
    run_slots(200, 0);
    repeat (20) @(negedge clk);
    chk(wave0 == 8'd100, "R6 200*128 upper byte", wave0, 100);
    volume0 = 8'd255;
    run_slots(200, 0);
    repeat (20) @(negedge clk);
    chk(wave0 == 8'd199, "R6 200*255 upper byte", wave0, 199);

    // R9: table rewritten but no slot, ticks reload the staged value
    for (int i = 0; i < 256; i++) wr(i, 50, 1'b0, 1'b0);
    wr_done();
    cnt = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      cnt += tick0;
    end
    chk(wave0 == 8'd199, "R9 stale staged value repeats", wave0, 199);
    chk(cnt > 0, "R9 ticks occurred", cnt, 1);

    // R8: writes during refresh slots are dropped
    for (int i = 0; i < 256; i++) wr(i, 7, 1'b1, 1'b1);
    wr_done();
    run_slots(300, 1);
    repeat (20) @(negedge clk);
    chk(wave0 == 8'd49, "R8 write in slot ignored", wave0, 49);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule